// File: doc/BRIEF.md
# Paged Register Map Decoder

This block decodes a 256-byte register space for a small serial-bus slave. The lower half of the space (00h to 7Fh) is always mapped. It holds 32 user bytes, 32 configuration bytes, a reserved gap and, at 7Fh, a page-select byte. The upper half (80h to FFh) is served by one of five external tables. The page-select value picks the table.

Each upper table fills only the first part of the upper half, and each table has its own extent. An access inside that extent drives the table's chip select and passes the low seven address bits as a local offset. An access outside it, in the reserved lower gap, or under a page-select value that names no table, is not populated. Such an access reads as 00h, its write is dropped, and it raises a one-cycle miss pulse.

Upper storage is laid out as 8-byte rows. A 16-bit word n of a row sits at the row base plus 2n, so a word access is two byte accesses at consecutive offsets. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

Top module: `pgmap_decoder`

## Requirements
- R1: Addresses 00h to 7Fh reach the lower page whatever the page-select value is. No access with address bit 7 clear asserts any table chip select.
- R2: The page-select byte sits at 7Fh. It resets to 00h, takes any written 8-bit value, and reads back that value.
- R3: An upper access (read or write) to a populated location asserts exactly one chip select in the strobe's cycle. Bit k of the chip select is asserted when the page-select value is k+1. `tbl_offset` equals the address minus 80h, and `tbl_wr` is high for writes only.
- R4: Each table's last populated address is its own. Table 1 ends at AFh, tables 2 and 3 end at C7h, and tables 4 and 5 end at BFh. Any address above the selected table's last address asserts no chip select.
- R5: When the page-select value is 00h or greater than 05h, no upper access asserts a chip select, and an upper read returns 00h.
- R6: A read from any unpopulated location returns 00h. A write to an unpopulated location changes no stored byte and raises no `tbl_wr`.
- R7: `rd_data` is updated at the clock edge that samples `bus_rd`. It holds its value through cycles with no read.
- R8: `miss` is high for exactly the one cycle after a read or write to an unpopulated location, and is low otherwise.
- R9: Addresses 00h to 1Fh (user) and 20h to 3Fh (configuration) store and return written bytes. All lower storage resets to 00h. Addresses 40h to 7Eh are reserved and unpopulated.
- R10: A lower-page write takes effect at its clock edge. A read of the same address in the same cycle returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| tbl_rdata | input | 40 | Read data of the five tables; table k+1 occupies bits 8k+7 to 8k |
| tbl_cs | output | 5 | Per-table chip select; bit k selects table k+1 |
| tbl_offset | output | 7 | Offset within the selected table |
| tbl_wr | output | 1 | Write enable toward the selected table |
| rd_data | output | 8 | Registered read data |
| miss | output | 1 | One-cycle pulse after an unpopulated access |

## Verification
The assertions check, on every cycle, these properties:
- At most one chip select is asserted.
- No chip select is asserted for a lower address or for an invalid page-select value.
- The page-select byte changes only on a write to 7Fh.
- `rd_data` holds when no read occurs.
- A miss always follows an access, and a read that missed returns zero.

Only the bench scenarios can show the other behaviours. These are the per-table extent boundaries at the last populated byte and the byte above it, and reads and writes that move data through the user, configuration and table storage. They also include same-cycle read-and-write ordering, and the reset contents of the lower page.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned OFFW = AW - 1;

  // Last populated offset (relative to the upper half) of table idx (1-based)
  function automatic logic [OFFW-1:0] tbl_last_off(input int unsigned idx);
    case (idx)
      1:       tbl_last_off = 7'h2F;
      2, 3:    tbl_last_off = 7'h47;
      4, 5:    tbl_last_off = 7'h3F;
      default: tbl_last_off = 7'h00;
    endcase
  endfunction

  // Whether a page-select value names an existing table
  function automatic logic sel_valid(input logic [DW-1:0] sel, input int unsigned ntbl);
    sel_valid = (sel != '0) && (int'(sel) <= ntbl);
  endfunction
endpackage

// File: rtl/pgmap_lower.sv
module pgmap_lower import pgmap_pkg::*; #(
  parameter int unsigned USER_N = 32,
  parameter int unsigned CFG_N  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OFFW-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_en,
  output logic [DW-1:0]   rdata,
  output logic            hit,
  output logic [DW-1:0]   sel_q
);
  localparam int unsigned STORE_N = USER_N + CFG_N;
  localparam logic [OFFW-1:0] SEL_ADDR = {OFFW{1'b1}};

  logic [DW-1:0] mem [STORE_N];
  logic          in_store;
  logic          at_sel;

  assign in_store = int'(addr) < STORE_N;
  assign at_sel   = (addr == SEL_ADDR);
  assign hit      = in_store || at_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STORE_N); i++) mem[i] <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      if (in_store) mem[addr] <= wdata;
      if (at_sel)   sel_q     <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_store)    rdata = mem[addr];
    else if (at_sel) rdata = sel_q;
  end

  // R2: page select moves only on a write to its address
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && at_sel) |=> $stable(sel_q));
endmodule

// File: rtl/pgmap_upper_dec.sv
module pgmap_upper_dec import pgmap_pkg::*; #(
  parameter int unsigned NTBL = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upper,
  input  logic            access,
  input  logic            wr,
  input  logic [OFFW-1:0] off,
  input  logic [DW-1:0]   sel,
  output logic [NTBL-1:0] cs,
  output logic            tbl_wr,
  output logic            hit
);
  logic [NTBL-1:0] in_ext;

  for (genvar g = 0; g < int'(NTBL); g++) begin : g_tbl
    assign in_ext[g] = upper && (sel == DW'(g + 1)) && (off <= tbl_last_off(g + 1));
    assign cs[g]     = access && in_ext[g];
  end

  assign hit    = |in_ext;
  assign tbl_wr = wr && hit;

  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));
  p_cs_lower_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !upper |-> (cs == '0));
  p_bad_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid(sel, NTBL) |-> (cs == '0));
  p_wr_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> (cs != '0));
endmodule

// File: rtl/pgmap_rdport.sv
module pgmap_rdport import pgmap_pkg::*; #(
  parameter int unsigned NTBL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             access,
  input  logic             upper,
  input  logic             hit,
  input  logic [DW-1:0]    sel,
  input  logic [DW-1:0]    lower_rdata,
  input  logic [NTBL*DW-1:0] tbl_rdata,
  output logic [DW-1:0]    rd_data,
  output logic             miss
);
  logic [DW-1:0] tbl_pick;
  logic [DW-1:0] rd_next;

  always_comb begin
    tbl_pick = '0;
    for (int t = 0; t < int'(NTBL); t++)
      if (sel == DW'(t + 1)) tbl_pick = tbl_rdata[t*DW +: DW];
  end

  always_comb begin
    if (!hit)       rd_next = '0;
    else if (upper) rd_next = tbl_pick;
    else            rd_next = lower_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      miss    <= 1'b0;
    end else begin
      if (rd) rd_data <= rd_next;
      miss <= access && !hit;
    end
  end

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rd_data));
  p_miss_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !miss);
  p_miss_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (rd_data == '0));
endmodule

// File: rtl/pgmap_decoder.sv
module pgmap_decoder import pgmap_pkg::*; #(
  parameter int unsigned NTBL   = 5,
  parameter int unsigned USER_N = 32,
  parameter int unsigned CFG_N  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [NTBL*DW-1:0] tbl_rdata,
  output logic [NTBL-1:0]    tbl_cs,
  output logic [OFFW-1:0]    tbl_offset,
  output logic               tbl_wr,
  output logic [DW-1:0]      rd_data,
  output logic               miss
);
  logic          upper;
  logic          access;
  logic          lo_hit;
  logic          up_hit;
  logic          any_hit;
  logic [DW-1:0] lo_rdata;
  logic [DW-1:0] sel_q;

  assign upper      = bus_addr[AW-1];
  assign access     = bus_rd || bus_wr;
  assign tbl_offset = bus_addr[OFFW-1:0];
  assign any_hit    = upper ? up_hit : lo_hit;

  pgmap_lower #(.USER_N(USER_N), .CFG_N(CFG_N)) u_lower (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr[OFFW-1:0]),
    .wdata (bus_wdata),
    .wr_en (bus_wr && !upper),
    .rdata (lo_rdata),
    .hit   (lo_hit),
    .sel_q (sel_q)
  );

  pgmap_upper_dec #(.NTBL(NTBL)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .upper  (upper),
    .access (access),
    .wr     (bus_wr),
    .off    (bus_addr[OFFW-1:0]),
    .sel    (sel_q),
    .cs     (tbl_cs),
    .tbl_wr (tbl_wr),
    .hit    (up_hit)
  );

  pgmap_rdport #(.NTBL(NTBL)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd          (bus_rd),
    .access      (access),
    .upper       (upper),
    .hit         (any_hit),
    .sel         (sel_q),
    .lower_rdata (lo_rdata),
    .tbl_rdata   (tbl_rdata),
    .rd_data     (rd_data),
    .miss        (miss)
  );
endmodule

// File: tb/pgmap_decoder_bench.sv
module pgmap_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [39:0] tbl_rdata;
  logic [4:0]  tbl_cs;
  logic [6:0]  tbl_offset;
  logic        tbl_wr;
  logic [7:0]  rd_data;
  logic        miss;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgmap_decoder u_pgmap_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .tbl_rdata(tbl_rdata), .tbl_cs(tbl_cs),
    .tbl_offset(tbl_offset), .tbl_wr(tbl_wr), .rd_data(rd_data), .miss(miss)
  );

  // External tables (responders)
  logic [7:0] tmem [1:5][0:127];
  always_comb
    for (int t = 0; t < 5; t++) tbl_rdata[t*8 +: 8] = tmem[t+1][tbl_offset];
  always @(posedge clk)
    for (int t = 0; t < 5; t++)
      if (tbl_wr && tbl_cs[t]) tmem[t+1][tbl_offset] <= bus_wdata;

  // Reference model state
  int lmem [0:63];
  int msel;
  int tref [1:5][0:127];
  int exp_rd;

  function automatic bit m_pop(input int a);
    if (a < 'h40 || a == 'h7F) return 1;
    if (a < 'h80) return 0;
    case (msel)
      1: return a <= 'hAF;
      2: return a <= 'hC7;
      3: return a <= 'hC7;
      4: return a <= 'hBF;
      5: return a <= 'hBF;
      default: return 0;
    endcase
  endfunction

  function automatic int m_val(input int a);
    if (!m_pop(a)) return 0;
    if (a < 'h40) return lmem[a];
    if (a == 'h7F) return msel;
    return tref[msel][a - 'h80];
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic acc(input bit rd, input bit wr, input int a, input int d, input string tag);
    int ecs, ewr, emiss;
    bit pop;
    bus_rd = rd; bus_wr = wr; bus_addr = 8'(a); bus_wdata = 8'(d);
    pop = m_pop(a);
    ecs = ((rd || wr) && a >= 'h80 && pop) ? (1 << (msel - 1)) : 0;
    ewr = (wr && a >= 'h80 && pop) ? 1 : 0;
    emiss = ((rd || wr) && !pop) ? 1 : 0;
    if (rd) exp_rd = m_val(a);
    #1;
    chk(tag, "tbl_cs", int'(tbl_cs), ecs);
    chk(tag, "tbl_wr", int'(tbl_wr), ewr);
    if (ecs != 0) chk(tag, "tbl_offset", int'(tbl_offset), a - 'h80);
    @(posedge clk);
    if (wr && pop) begin
      if (a < 'h40) lmem[a] = d;
      else if (a == 'h7F) msel = d;
      else tref[msel][a - 'h80] = d;
    end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    chk(tag, "rd_data", int'(rd_data), exp_rd);
    chk(tag, "miss", int'(miss), emiss);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int t = 1; t <= 5; t++)
      for (int o = 0; o < 128; o++) begin
        tmem[t][o] = 8'((t * 37 + o * 5) ^ 'h5A);
        tref[t][o] = (t * 37 + o * 5) ^ 'h5A;
        tref[t][o] = tref[t][o] & 'hFF;
      end
    for (int i = 0; i < 64; i++) lmem[i] = 0;
    msel = 0; exp_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    chk("R7", "rd_data reset", int'(rd_data), 0);
    acc(1, 0, 'h7F, 0, "R2");
    acc(1, 0, 'h05, 0, "R9");
    acc(1, 0, 'h3E, 0, "R9");

    // Lower storage
    for (int i = 0; i < 64; i += 7) acc(0, 1, i, (i * 11 + 3) & 'hFF, "R9");
    acc(0, 1, 'h1F, 'hC3, "R9");
    acc(0, 1, 'h20, 'h3C, "R9");
    for (int i = 0; i < 64; i += 7) acc(1, 0, i, 0, "R9");
    acc(1, 0, 'h1F, 0, "R9");
    acc(1, 0, 'h20, 0, "R9");

    // Reserved gap
    acc(0, 1, 'h40, 'hAA, "R6");
    acc(1, 0, 'h40, 0, "R6");
    acc(0, 1, 'h7E, 'h55, "R8");
    acc(1, 0, 'h7E, 0, "R8");

    // Invalid selects
    acc(1, 0, 'h80, 0, "R5");
    acc(0, 1, 'h81, 'h99, "R5");
    acc(0, 1, 'h7F, 'h09, "R2");
    acc(1, 0, 'h7F, 0, "R2");
    acc(1, 0, 'h90, 0, "R5");
    acc(1, 0, 'h1F, 0, "R1");
    acc(0, 1, 'h02, 'h77, "R1");
    acc(1, 0, 'h02, 0, "R1");

    // Each table: extents, data, writes
    for (int t = 1; t <= 5; t++) begin
      int last;
      last = (t == 1) ? 'hAF : (t <= 3) ? 'hC7 : 'hBF;
      acc(0, 1, 'h7F, t, "R2");
      acc(1, 0, 'h80, 0, "R3");
      acc(1, 0, last, 0, "R4");
      acc(1, 0, last + 1, 0, "R4");
      acc(0, 1, last + 1, 'hEE, "R4");
      acc(1, 0, 'hFF, 0, "R4");
      acc(0, 1, 'h80 + 2 * t, 'h10 + t, "R3");
      acc(1, 0, 'h80 + 2 * t, 0, "R3");
      acc(1, 0, 'h0E, 0, "R1");
    end

    // Hold between reads
    acc(1, 0, 'h07, 0, "R7");
    acc(0, 0, 'h00, 0, "R7");
    acc(0, 1, 'h08, 'h42, "R7");
    acc(0, 0, 'h85, 0, "R7");

    // Same-cycle read and write
    acc(1, 1, 'h0A, 'hB7, "R10");
    acc(1, 0, 'h0A, 0, "R10");
    acc(1, 1, 'h7F, 'h03, "R10");
    acc(1, 0, 'h7F, 0, "R10");

    finish_up();
  end
endmodule